// File: doc/BRIEF.md
# Boot-time RAM image loader

This block fills a set of on-chip RAMs from a byte-wide nonvolatile store before the processor core runs. Out of reset it requests the shared bus and waits for the grant. Once granted, it fetches the image one byte at a time, at a fixed number of cycles per byte. It assembles each target RAM's word from as many bytes as that width needs and writes the word with the RAM's own chip select and address. A RAM whose width is not a whole number of bytes has its surplus upper bits cleared.

One linear byte counter sequences the whole image. That counter is the flash address, and the RAM boundaries are decoded from it. The word address starts again at zero for each RAM. After the last word is written, the loader drops its bus request and raises a start signal for the core. It then stays idle until the next reset.

The RAM list is set by parameters. The defaults used below are:
- RAM 0: 32 bits wide, 8 words.
- RAM 1: 8 bits wide, 4 words.
- RAM 2: 11 bits wide, 4 words.

With these defaults the image is 44 bytes long.

Top module: `boot_ram_loader`

## Requirements
- R1: While reset is held, `bus_req`, `fl_rd`, `ram_cs`, `ram_we` and `boot_start` are all low. One cycle after reset is released, `bus_req` goes high. No flash read, chip select or write occurs before `bus_gnt` has been seen high.
- R2: Loading begins at flash byte address 0. While `fl_rd` is high, `fl_addr` holds each address for exactly 4 cycles and then steps by one. It runs continuously through the whole image without returning to zero between RAMs. The load takes 178 cycles from the grant to `boot_start`.
- R3: Bytes are packed little-endian: the first byte fetched for a word lands in bits [7:0]. `ram_we` is a single-cycle pulse in the cycle right after the word's last byte is taken. In that cycle `fl_addr` already shows the next byte.
- R4: For a RAM narrower than its byte count times 8, the bits above its width are zero in `ram_wdata`. For the 11-bit RAM, the high 5 bits of the 16-bit pair are dropped.
- R5: `ram_addr` is 0 for the first word written to each RAM and increases by one for each further word.
- R6: `ram_cs` is one-hot. Bit i selects RAM i. While bytes are fetched, the set bit is the RAM that owns the current byte; ownership switches at cumulative byte counts 32 and 36. During a write pulse, the set bit is the RAM being written, even at a boundary.
- R7: After the last write, `bus_req`, `fl_rd` and `ram_cs` go low and `boot_start` goes high. `boot_start` stays high with no further writes.
- R8: Reset applied during loading clears all outputs at once. After release, the loader repeats the whole sequence from byte 0 with a new bus request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | output | 1 | Shared-bus request |
| bus_gnt | input | 1 | Shared-bus grant |
| fl_rd | output | 1 | Byte read active on the external store |
| fl_addr | output | FADDR_W (16) | External byte address |
| fl_data | input | 8 | Byte returned by the external store |
| ram_cs | output | NUM_RAMS (3) | One chip select per target RAM |
| ram_we | output | 1 | Word write strobe |
| ram_addr | output | ADDR_W (3) | Word address within the selected RAM |
| ram_wdata | output | MAX_W (32) | Packed, truncated write word |
| boot_start | output | 1 | Load finished, core may start |

## Verification
The risky coincidence is at a RAM boundary. There, the write of one RAM's final word falls in the same cycle as the chip-select and address switch-over to the next RAM. The first byte fetch for the new RAM starts in that cycle too. The bench triggers this at both boundaries (bytes 32 and 36) and at the end of the image, in every run. Each write is judged by three things together: the chip select of the RAM that owns the word, that RAM's local address, and a flash address that has already moved past the word.

// File: rtl/boot_ram_loader.sv
module boot_ram_loader #(
  parameter int NUM_RAMS            = 3,
  parameter int RAM_W [NUM_RAMS]    = '{32, 8, 11},
  parameter int RAM_D [NUM_RAMS]    = '{8, 4, 4},
  parameter int RD_CYCLES           = 4,
  parameter int MAX_W               = 32,
  parameter int ADDR_W              = 3,
  parameter int FADDR_W             = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                bus_req,
  input  logic                bus_gnt,
  output logic                fl_rd,
  output logic [FADDR_W-1:0]  fl_addr,
  input  logic [7:0]          fl_data,
  output logic [NUM_RAMS-1:0] ram_cs,
  output logic                ram_we,
  output logic [ADDR_W-1:0]   ram_addr,
  output logic [MAX_W-1:0]    ram_wdata,
  output logic                boot_start
);

  function automatic int bytes_of(int w);
    return (w + 7) / 8;
  endfunction

  function automatic int bound_of(int i);
    int s = 0;
    for (int j = 0; j <= i; j++) s += RAM_D[j] * bytes_of(RAM_W[j]);
    return s;
  endfunction

  localparam int MAX_B = bytes_of(MAX_W);
  localparam int LW    = (MAX_B > 1) ? $clog2(MAX_B) : 1;
  localparam int IW    = (NUM_RAMS > 1) ? $clog2(NUM_RAMS) : 1;
  localparam int RW    = (RD_CYCLES > 1) ? $clog2(RD_CYCLES) : 1;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_LOAD, S_FIN, S_DONE} st_t;

  st_t                  st;
  logic [RW-1:0]        rd_cnt;
  logic [FADDR_W-1:0]   byte_cnt;
  logic [LW-1:0]        lane;
  logic [IW-1:0]        idx, widx_q;
  logic [ADDR_W-1:0]    waddr, wad_q;
  logic [MAX_B*8-1:0]   pack, pack_nx;
  logic                 we_q;
  logic [MAX_W-1:0]     wdata_q;

  logic [FADDR_W-1:0]   bnd       [NUM_RAMS];
  logic [LW-1:0]        last_lane [NUM_RAMS];
  logic [MAX_W-1:0]     wmask     [NUM_RAMS];

  for (genvar g = 0; g < NUM_RAMS; g++) begin : g_ram
    assign bnd[g]       = FADDR_W'(bound_of(g));
    assign last_lane[g] = LW'(bytes_of(RAM_W[g]) - 1);
    assign wmask[g]     = MAX_W'((64'd1 << RAM_W[g]) - 64'd1);
  end

  wire grab     = (st == S_LOAD) && (rd_cnt == RW'(RD_CYCLES - 1));
  wire word_end = (lane == last_lane[idx]);
  wire ram_end  = (byte_cnt + FADDR_W'(1) == bnd[idx]);
  wire last_ram = (idx == IW'(NUM_RAMS - 1));

  always_comb begin
    pack_nx = pack;
    pack_nx[{lane, 3'b000} +: 8] = fl_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      rd_cnt   <= '0;
      byte_cnt <= '0;
      lane     <= '0;
      idx      <= '0;
      widx_q   <= '0;
      waddr    <= '0;
      wad_q    <= '0;
      pack     <= '0;
      we_q     <= 1'b0;
      wdata_q  <= '0;
    end else begin
      we_q <= 1'b0;
      case (st)
        S_IDLE: st <= S_REQ;
        S_REQ:  if (bus_gnt) st <= S_LOAD;
        S_LOAD: begin
          rd_cnt <= grab ? '0 : rd_cnt + RW'(1);
          if (grab) begin
            byte_cnt <= byte_cnt + FADDR_W'(1);
            if (word_end) begin
              we_q    <= 1'b1;
              wdata_q <= pack_nx[MAX_W-1:0] & wmask[idx];
              wad_q   <= waddr;
              widx_q  <= idx;
              waddr   <= waddr + ADDR_W'(1);
              lane    <= '0;
              pack    <= '0;
            end else begin
              lane <= lane + LW'(1);
              pack <= pack_nx;
            end
            if (ram_end) begin
              waddr <= '0;
              if (last_ram) st <= S_FIN;
              else          idx <= idx + IW'(1);
            end
          end
        end
        S_FIN:   st <= S_DONE;
        default: ;
      endcase
    end
  end

  always_comb begin
    ram_cs = '0;
    if (we_q)              ram_cs[widx_q] = 1'b1;
    else if (st == S_LOAD) ram_cs[idx]    = 1'b1;
  end

  assign bus_req    = (st == S_REQ) || (st == S_LOAD) || (st == S_FIN);
  assign fl_rd      = (st == S_LOAD);
  assign fl_addr    = byte_cnt;
  assign ram_we     = we_q;
  assign ram_addr   = wad_q;
  assign ram_wdata  = wdata_q;
  assign boot_start = (st == S_DONE);

endmodule

// File: rtl/boot_ram_loader_chk.sv
module boot_ram_loader_chk #(
  parameter int NUM_RAMS  = 3,
  parameter int RD_CYCLES = 4,
  parameter int FADDR_W   = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_req,
  input logic                bus_gnt,
  input logic                fl_rd,
  input logic [FADDR_W-1:0]  fl_addr,
  input logic [NUM_RAMS-1:0] ram_cs,
  input logic                ram_we,
  input logic                boot_start
);

  logic               granted, prev_rd;
  logic [FADDR_W-1:0] prev_addr;
  int                 hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      granted   <= 1'b0;
      prev_rd   <= 1'b0;
      prev_addr <= '0;
      hold      <= 0;
    end else begin
      if (bus_req && bus_gnt) granted <= 1'b1;
      prev_rd   <= fl_rd;
      prev_addr <= fl_addr;
      if (!fl_rd)                              hold <= 0;
      else if (prev_rd && fl_addr != prev_addr) hold <= 1;
      else                                     hold <= hold + 1;
    end
  end

  p_no_touch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !granted |-> (!fl_rd && ram_cs == '0 && !ram_we));

  p_byte_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_rd && prev_rd && fl_addr != prev_addr) |-> (hold == RD_CYCLES));

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_rd && prev_rd) |-> (fl_addr == prev_addr || fl_addr == prev_addr + FADDR_W'(1)));

  p_we_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> !ram_we);

  p_cs_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ram_cs));

  p_we_has_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $countones(ram_cs) == 1);

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    boot_start |-> (!bus_req && !fl_rd && ram_cs == '0 && !ram_we));

  p_boot_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    boot_start |=> boot_start);

endmodule

bind boot_ram_loader boot_ram_loader_chk #(
  .NUM_RAMS(NUM_RAMS), .RD_CYCLES(RD_CYCLES), .FADDR_W(FADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .fl_rd(fl_rd), .fl_addr(fl_addr), .ram_cs(ram_cs), .ram_we(ram_we),
  .boot_start(boot_start)
);

// File: tb/boot_ram_loader_tb.sv
`timescale 1ns/100ps
module boot_ram_loader_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_gnt = 1'b0;
  logic        bus_req, fl_rd, ram_we, boot_start;
  logic [15:0] fl_addr;
  logic [7:0]  fl_data;
  logic [2:0]  ram_cs;
  logic [2:0]  ram_addr;
  logic [31:0] ram_wdata;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] fb(input logic [15:0] a);
    return 8'((a * 37) + 11);
  endfunction
  assign fl_data = fb(fl_addr);

  boot_ram_loader u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .fl_rd(fl_rd), .fl_addr(fl_addr), .fl_data(fl_data), .ram_cs(ram_cs),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .boot_start(boot_start)
  );

  int checks = 0;
  int errors = 0;
  int wr_n = 0;
  int run = 0;
  logic prev_rd = 1'b0;
  logic seen_gnt = 1'b0;
  logic [15:0] prev_addr = '0;
  bit done_flag = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ram_of_word(int n);
    return (n < 8) ? 0 : (n < 12) ? 1 : 2;
  endfunction
  function automatic int ram_of_byte(int a);
    return (a < 32) ? 0 : (a < 36) ? 1 : 2;
  endfunction
  function automatic int local_k(int n);
    return (n < 8) ? n : (n < 12) ? n - 8 : n - 12;
  endfunction
  function automatic int bpw(int r);
    return (r == 0) ? 4 : (r == 1) ? 1 : 2;
  endfunction
  function automatic int base_of(int r);
    return (r == 0) ? 0 : (r == 1) ? 32 : 36;
  endfunction
  function automatic int word_end(int n);
    int r = ram_of_word(n);
    return base_of(r) + (local_k(n) + 1) * bpw(r);
  endfunction
  function automatic logic [31:0] exp_data(int n);
    logic [31:0] v = '0;
    int r = ram_of_word(n);
    int s = base_of(r) + local_k(n) * bpw(r);
    for (int b = 0; b < bpw(r); b++) v[b*8 +: 8] = fb(16'(s + b));
    if (r == 2) v = v & 32'h7FF;
    return v;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      wr_n = 0; run = 0; prev_rd = 1'b0; seen_gnt = 1'b0;
    end else begin
      if (!seen_gnt && (ram_cs != 3'b0 || ram_we || fl_rd))
        chk(1'b0, "R1 memory touched before grant", {29'b0, ram_cs}, 32'h0);
      if (bus_gnt) seen_gnt = 1'b1;
      if (ram_we) begin
        chk(wr_n < 16, "R7 extra write", wr_n, 16);
        chk(ram_cs == 3'(1 << ram_of_word(wr_n)), "R6 cs on write", {29'b0, ram_cs}, 1 << ram_of_word(wr_n));
        chk(ram_addr == 3'(local_k(wr_n)), "R5 word address", {29'b0, ram_addr}, local_k(wr_n));
        chk(ram_wdata == exp_data(wr_n), ram_of_word(wr_n) == 2 ? "R4 truncated word" : "R3 packed word",
            ram_wdata, exp_data(wr_n));
        chk(fl_addr == 16'(word_end(wr_n)), "R3 write timing", {16'b0, fl_addr}, word_end(wr_n));
        wr_n++;
      end else if (fl_rd) begin
        chk(ram_cs == 3'(1 << ram_of_byte(int'(fl_addr))), "R6 cs while fetching", {29'b0, ram_cs},
            1 << ram_of_byte(int'(fl_addr)));
      end
      if (fl_rd) begin
        if (!prev_rd) begin
          chk(fl_addr == 16'd0, "R2 start address", {16'b0, fl_addr}, 0);
          run = 1;
        end else if (fl_addr != prev_addr) begin
          chk(run == 4 && fl_addr == prev_addr + 16'd1, "R2 byte rate", run, 4);
          run = 1;
        end else run++;
      end
      prev_rd = fl_rd;
      prev_addr = fl_addr;
    end
  end

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bus_gnt = 1'b0;
    repeat (3) @(negedge clk);
    chk(!bus_req && !fl_rd && ram_cs == 3'b0 && !ram_we && !boot_start, "R1 reset state",
        {bus_req, fl_rd, ram_cs, ram_we, boot_start}, 0);
  endtask

  task automatic run_load(input int gdelay, input int exp_cycles);
    int cyc = 0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_req, "R1 request after reset", bus_req, 1);
    repeat (gdelay) @(negedge clk);
    chk(!fl_rd && wr_n == 0, "R1 waits for grant", fl_rd, 0);
    bus_gnt = 1'b1;
    while (!boot_start && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == exp_cycles, "R2 load duration", cyc, exp_cycles);
    chk(boot_start && !bus_req && !fl_rd && ram_cs == 3'b0, "R7 release and start",
        {boot_start, bus_req, fl_rd, ram_cs}, 32'h20);
    chk(wr_n == 16, "R7 all words written", wr_n, 16);
    bus_gnt = 1'b0;
    repeat (5) @(negedge clk);
    chk(boot_start && wr_n == 16 && !bus_req, "R7 stays idle", {boot_start, bus_req}, 32'h2);
  endtask

  localparam int VEC [4][2] = '{'{0, 178}, '{1, 178}, '{6, 178}, '{23, 178}};

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      do_reset();
      run_load(VEC[i][0], VEC[i][1]);
    end

    do_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_gnt = 1'b1;
    while (wr_n < 9) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!bus_req && !fl_rd && ram_cs == 3'b0 && !ram_we && !boot_start && fl_addr == 16'd0,
        "R8 abort clears outputs", {bus_req, fl_rd, ram_cs, ram_we, boot_start}, 0);
    bus_gnt = 1'b0;
    repeat (2) @(negedge clk);
    run_load(2, 178);

    finish_up();
  end

endmodule